// File: doc/BRIEF.md
# Bayer Line-Buffer Window Generator

This block takes a raster stream of raw colour-filter-array pixels, one pixel per accepted transfer, and turns it into a stream of 5x5 neighbourhoods, one for every pixel of the image, in raster order. Each neighbourhood goes to interpolation logic further down the pipeline. Alongside it come two tags: a colour tag for the centre pixel and a flag that says whether the centre sits close enough to an image edge to need simple bilinear treatment instead of the gradient-directed interior method.

Complete lines are kept in a ring of six line memories. A small controller decides which memory takes the incoming line and which five supply the window. It moves every role on by one memory each time a line is finished. Image width, image height and the row/column parity of the first red pixel are control inputs. They are captured on a start-of-frame pulse, so the same hardware serves any of the four 2x2 colour arrangements. Where a window reaches past an image edge, the missing taps repeat the nearest pixel inside the image. The last two rows are drained once the final line has arrived, so the block emits exactly one window per input pixel.

Both data interfaces are valid/ready. A transfer happens on a rising edge where valid and ready are both high. The input side drops ready while accepting another line would overwrite a line that a window still needs, or after all lines of the frame are in. The output side keeps the window and both tags unchanged while valid is high and ready is low. Nothing is dropped or repeated under back-pressure on either side.

Top module: `bayer_window_gen`

## Requirements
- R1: After reset, and until the first `sof` pulse, `in_ready` and `out_valid` stay low, so no pixel is accepted and no window is issued.
- R2: Each window is centred on the pixel at (row r, column c) and carries 25 taps of `DW` bits each (`DW` may be 12, 14 or 16). Tap t = 5*(dr+2) + (dc+2) holds the pixel at (r+dr, c+dc) for dr, dc in -2..2, and tap t sits at bits [t*DW +: DW] of `out_win`.
- R3: A tap whose row lies outside 0..height-1, or whose column lies outside 0..width-1, takes the pixel at the nearest in-range row and column. In other words, each coordinate is clamped on its own.
- R4: The first window of a frame is not issued until min(5, height) complete lines have been accepted.
- R5: A frame of width W and height H yields exactly W*H windows, in raster order and one for each accepted pixel. After the last window, `out_valid` and `in_ready` stay low until the next `sof`.
- R6: `out_phase` = {row[0] XOR red_row, col[0] XOR red_col}. Here 0 means red, 1 green on a red row, 2 green on a blue row and 3 blue. A red parity of (0,0) is RGGB, (0,1) GRBG, (1,0) GBRG and (1,1) BGGR.
- R7: `out_border` is 1 when the centre row is < 2 or > H-3, or the centre column is < 2 or > W-3. It is 0 otherwise.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high, and `out_win`, `out_phase` and `out_border` are unchanged.
- R9: A line is never written into a memory that supplies taps to the window being issued. When the output is stalled from the start of a frame, the block accepts six lines and then holds `in_ready` low.
- R10: A `sof` pulse in the middle of a frame abandons that frame. It loads the new settings and restarts line, rotation and fill counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse; captures the settings and restarts the counters |
| cfg_width | input | $clog2(MAX_W+1) | Line length in pixels, 1..MAX_W |
| cfg_height | input | $clog2(MAX_H+1) | Frame height in lines, 1..MAX_H |
| cfg_red_row | input | 1 | Row parity of the first red pixel |
| cfg_red_col | input | 1 | Column parity of the first red pixel |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | DW | Raw pixel value |
| out_valid | output | 1 | Window valid |
| out_ready | input | 1 | Downstream accepts the window |
| out_win | output | 25*DW | 5x5 neighbourhood, tap order as in R2 |
| out_phase | output | 2 | Colour tag of the centre pixel (R6) |
| out_border | output | 1 | Centre needs edge treatment (R7) |

## Verification
The window and its tags are combinational from the output counters and the line memories. They therefore belong to the same cycle in which `out_valid` is seen, and they change only on the edge after a completed transfer. `in_ready` is likewise decided in the current cycle, and a pixel accepted on an edge can appear in windows only after its whole line has been stored. The bench drives inputs on the falling edge and samples 1 ns later. It counts a transfer only where valid and ready are both seen high in that sample, and the R4 fill count uses only pixels accepted on earlier edges. The bench checks R9 at a fixed cycle of an output stall that begins with the frame, when exactly six lines must have been taken.

// File: rtl/bwin_pkg.sv
`timescale 1ns/1ps
package bwin_pkg;
  localparam int TAPS  = 5;
  localparam int NSLOT = 6;
  localparam int SLW   = 3;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GRN_R = 2'd1,
    PH_GRN_B = 2'd2,
    PH_BLUE  = 2'd3
  } phase_t;

  function automatic logic [SLW-1:0] slot_next(input logic [SLW-1:0] s);
    return (s == SLW'(NSLOT-1)) ? '0 : s + SLW'(1);
  endfunction
endpackage

// File: rtl/bwin_line_store.sv
`timescale 1ns/1ps
module bwin_line_store import bwin_pkg::*; #(
  parameter int DW    = 12,
  parameter int MAX_W = 64,
  localparam int AW   = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [SLW-1:0]                wr_slot,
  input  logic [AW-1:0]                 wr_col,
  input  logic [DW-1:0]                 wr_data,
  input  logic [TAPS-1:0][SLW-1:0]      rd_slot,
  input  logic [TAPS-1:0][AW-1:0]       rd_col,
  output logic [TAPS*TAPS*DW-1:0]       taps
);
  logic [DW-1:0] mem [NSLOT][MAX_W];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot][wr_col] <= wr_data;
  end

  for (genvar r = 0; r < TAPS; r++) begin : g_row
    for (genvar c = 0; c < TAPS; c++) begin : g_col
      assign taps[(r*TAPS+c)*DW +: DW] = mem[rd_slot[r]][rd_col[c]];
    end
  end
endmodule

// File: rtl/bwin_ctrl.sv
`timescale 1ns/1ps
module bwin_ctrl import bwin_pkg::*; #(
  parameter int MAX_W = 64,
  parameter int MAX_H = 1024,
  localparam int LW   = $clog2(MAX_W+1),
  localparam int HW   = $clog2(MAX_H+1),
  localparam int AW   = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof,
  input  logic [LW-1:0]            cfg_w,
  input  logic [HW-1:0]            cfg_h,
  input  logic                     cfg_rr,
  input  logic                     cfg_rc,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic                     wr_en,
  output logic [SLW-1:0]           wr_slot,
  output logic [AW-1:0]            wr_col,
  output logic [TAPS-1:0][SLW-1:0] rd_slot,
  output logic [TAPS-1:0][AW-1:0]  rd_col,
  output logic [HW-1:0]            o_row,
  output logic [AW-1:0]            o_col,
  output logic                     o_last,
  output logic [LW-1:0]            fw,
  output logic [HW-1:0]            fh,
  output logic                     red_row,
  output logic                     red_col
);
  logic           active;
  logic [HW-1:0]  wr_row;
  logic [SLW-1:0] o_slot;
  logic [HW+1:0]  need;
  logic           in_fire, out_fire, wr_last;

  // lines that must be stored before the current output row may be issued
  always_comb begin
    need = (HW+2)'(o_row) + (HW+2)'(3);
    if (need < (HW+2)'(5)) need = (HW+2)'(5);
    if (need > (HW+2)'(fh)) need = (HW+2)'(fh);
  end

  assign out_valid = active && (o_row < fh) && ((HW+2)'(wr_row) >= need);
  assign in_ready  = active && (wr_row < fh) &&
                     ((wr_row < HW'(NSLOT)) || ((HW+2)'(o_row) + (HW+2)'(3) >= (HW+2)'(wr_row)));
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign wr_en     = in_fire;
  assign wr_last   = (LW'(wr_col) == fw - LW'(1));
  assign o_last    = (LW'(o_col) == fw - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      fw      <= '0;
      fh      <= '0;
      red_row <= 1'b0;
      red_col <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_slot <= '0;
      o_row   <= '0;
      o_col   <= '0;
      o_slot  <= '0;
    end else if (sof) begin
      active  <= 1'b1;
      fw      <= cfg_w;
      fh      <= cfg_h;
      red_row <= cfg_rr;
      red_col <= cfg_rc;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_slot <= '0;
      o_row   <= '0;
      o_col   <= '0;
      o_slot  <= '0;
    end else begin
      if (in_fire) begin
        if (wr_last) begin
          wr_col  <= '0;
          wr_row  <= wr_row + HW'(1);
          wr_slot <= slot_next(wr_slot);
        end else begin
          wr_col  <= wr_col + AW'(1);
        end
      end
      if (out_fire) begin
        if (o_last) begin
          o_col  <= '0;
          o_row  <= o_row + HW'(1);
          o_slot <= slot_next(o_slot);
        end else begin
          o_col  <= o_col + AW'(1);
        end
      end
    end
  end

  // tap addresses with edge clamping; slot offset follows the clamped row
  always_comb begin
    for (int d = 0; d < TAPS; d++) begin
      int rr, cc, s;
      rr = int'(o_row) + d - 2;
      if (rr > int'(fh) - 1) rr = int'(fh) - 1;
      if (rr < 0) rr = 0;
      s = int'(o_slot) + rr - int'(o_row);
      if (s < 0) s = s + NSLOT;
      if (s >= NSLOT) s = s - NSLOT;
      rd_slot[d] = SLW'(s);
      cc = int'(o_col) + d - 2;
      if (cc > int'(fw) - 1) cc = int'(fw) - 1;
      if (cc < 0) cc = 0;
      rd_col[d] = AW'(cc);
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!in_ready && !out_valid));

  // R9
  wr_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && out_valid) |-> (wr_slot != rd_slot[0] && wr_slot != rd_slot[1] &&
                                wr_slot != rd_slot[2] && wr_slot != rd_slot[3] &&
                                wr_slot != rd_slot[4]));

  // R4
  fill_before_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wr_row >= HW'(5) || wr_row == fh));

  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n || sof)
    (in_fire && wr_last && wr_row == fh - HW'(1)) |=> !in_ready);
endmodule

// File: rtl/bwin_tagger.sv
`timescale 1ns/1ps
module bwin_tagger import bwin_pkg::*; #(
  parameter int MAX_W = 64,
  parameter int MAX_H = 1024,
  localparam int LW   = $clog2(MAX_W+1),
  localparam int HW   = $clog2(MAX_H+1),
  localparam int AW   = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
  input  logic [HW-1:0] row,
  input  logic [AW-1:0] col,
  input  logic [LW-1:0] fw,
  input  logic [HW-1:0] fh,
  input  logic          red_row,
  input  logic          red_col,
  output phase_t        phase,
  output logic          border
);
  logic          row_par, col_par;
  logic [HW:0]   row_end;
  logic [LW:0]   col_end;

  assign row_par = row[0] ^ red_row;
  assign col_par = col[0] ^ red_col;
  assign phase   = phase_t'({row_par, col_par});

  assign row_end = (HW+1)'(row) + (HW+1)'(2);
  assign col_end = (LW+1)'(col) + (LW+1)'(2);
  assign border  = (row < HW'(2)) || (col < AW'(2)) ||
                   (row_end >= (HW+1)'(fh)) || (col_end >= (LW+1)'(fw));
endmodule

// File: rtl/bayer_window_gen.sv
`timescale 1ns/1ps
module bayer_window_gen import bwin_pkg::*; #(
  parameter int DW    = 12,
  parameter int MAX_W = 64,
  parameter int MAX_H = 1024,
  localparam int LW   = $clog2(MAX_W+1),
  localparam int HW   = $clog2(MAX_H+1),
  localparam int AW   = (MAX_W > 1) ? $clog2(MAX_W) : 1,
  localparam int WINW = TAPS*TAPS*DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof,
  input  logic [LW-1:0]   cfg_width,
  input  logic [HW-1:0]   cfg_height,
  input  logic            cfg_red_row,
  input  logic            cfg_red_col,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WINW-1:0] out_win,
  output logic [1:0]      out_phase,
  output logic            out_border
);
  logic                     wr_en;
  logic [SLW-1:0]           wr_slot;
  logic [AW-1:0]            wr_col;
  logic [TAPS-1:0][SLW-1:0] rd_slot;
  logic [TAPS-1:0][AW-1:0]  rd_col;
  logic [HW-1:0]            o_row;
  logic [AW-1:0]            o_col;
  logic                     o_last;
  logic [LW-1:0]            fw;
  logic [HW-1:0]            fh;
  logic                     red_row, red_col;
  phase_t                   phase;

  initial begin
    assert (DW == 12 || DW == 14 || DW == 16) else $error("DW must be 12, 14 or 16");
  end

  bwin_ctrl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sof(sof),
    .cfg_w(cfg_width), .cfg_h(cfg_height), .cfg_rr(cfg_red_row), .cfg_rc(cfg_red_col),
    .in_valid(in_valid), .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_col(wr_col), .rd_slot(rd_slot), .rd_col(rd_col),
    .o_row(o_row), .o_col(o_col), .o_last(o_last), .fw(fw), .fh(fh),
    .red_row(red_row), .red_col(red_col)
  );

  bwin_line_store #(.DW(DW), .MAX_W(MAX_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_col(wr_col), .wr_data(in_data),
    .rd_slot(rd_slot), .rd_col(rd_col), .taps(out_win)
  );

  bwin_tagger #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_tag (
    .row(o_row), .col(o_col), .fw(fw), .fh(fh),
    .red_row(red_row), .red_col(red_col), .phase(phase), .border(out_border)
  );

  assign out_phase = phase;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || sof)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_win) &&
                                   $stable(out_phase) && $stable(out_border)));

  // R6
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n || sof)
    (out_valid && out_ready && !o_last) |=> (out_phase[0] != $past(out_phase[0])));

  // R7
  left_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_col == '0) |-> out_border);
endmodule

// File: tb/bayer_window_gen_tb.sv
`timescale 1ns/1ps
module bayer_window_gen_tb;
  localparam int DW    = 12;
  localparam int MAX_W = 64;
  localparam int MAX_H = 1024;
  localparam int LW    = $clog2(MAX_W+1);
  localparam int HW    = $clog2(MAX_H+1);
  localparam int WINW  = 25*DW;
  localparam int FH    = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sof = 1'b0;
  logic [LW-1:0]   cfg_width = '0;
  logic [HW-1:0]   cfg_height = '0;
  logic            cfg_red_row = 1'b0;
  logic            cfg_red_col = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [DW-1:0]   in_data = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [WINW-1:0] out_win;
  logic [1:0]      out_phase;
  logic            out_border;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int fr [FH][MAX_W];

  always #4 clk = ~clk;

  bayer_window_gen #(.DW(DW), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_red_row(cfg_red_row), .cfg_red_col(cfg_red_col), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_win(out_win), .out_phase(out_phase), .out_border(out_border)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WINW-1:0] act, input logic [WINW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    return v;
  endfunction

  function automatic logic [WINW-1:0] exp_win(int r, int c, int w, int h);
    logic [WINW-1:0] v;
    for (int t = 0; t < 25; t++) begin
      int rr, cc;
      rr = clampi(r + t/5 - 2, 0, h-1);
      cc = clampi(c + t%5 - 2, 0, w-1);
      v[t*DW +: DW] = DW'(fr[rr][cc]);
    end
    return v;
  endfunction

  task automatic run_frame(int w, int h, bit rr, bit rc, int vprob, int rprob,
                           int stall, int abort_at);
    int acc, oc, guard, minl;
    bit first, hold;
    logic [WINW-1:0] prev;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) fr[r][c] = int'($urandom & ((1 << DW) - 1));
    @(negedge clk);
    sof = 1'b1; cfg_width = LW'(w); cfg_height = HW'(h);
    cfg_red_row = rr; cfg_red_col = rc;
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    sof = 1'b0;
    acc = 0; oc = 0; guard = 0; first = 0; hold = 0; prev = '0;
    minl = (h < 5) ? h : 5;
    while (oc < w*h && guard < 20000 && !(abort_at > 0 && acc >= abort_at)) begin
      @(negedge clk);
      guard++;
      in_valid = (acc < w*h) && (($urandom % 100) < vprob);
      in_data  = (acc < w*h) ? DW'(fr[acc/w][acc%w]) : '0;
      out_ready = (guard <= stall) ? 1'b0 : (($urandom % 100) < rprob);
      #1;
      if (stall > 0 && guard == stall) begin
        // R9: six lines taken, then input held off
        chk(acc == 6*w, "R9", "pixels accepted under output stall", WINW'(acc), WINW'(6*w));
        chk(!in_ready, "R9", "in_ready under output stall", WINW'(in_ready), '0);
      end
      if (hold) chk(out_valid && out_win == prev, "R8", "window held while stalled",
                    out_win, prev);
      if (out_valid && !first) begin
        first = 1;
        chk(acc >= minl*w, "R4", "pixels stored before first window", WINW'(acc), WINW'(minl*w));
      end
      if (out_valid && out_ready) begin
        int r, c;
        bit bexp;
        r = oc / w; c = oc % w;
        bexp = (r < 2) || (r > h-3) || (c < 2) || (c > w-3);
        chk(out_win == exp_win(r, c, w, h), bexp ? "R3" : "R2", "window taps",
            out_win, exp_win(r, c, w, h));
        chk(out_phase == {1'(r & 1) ^ rr, 1'(c & 1) ^ rc}, "R6", "phase tag",
            WINW'(out_phase), WINW'({1'(r & 1) ^ rr, 1'(c & 1) ^ rc}));
        chk(out_border == bexp, "R7", "border flag", WINW'(out_border), WINW'(bexp));
        oc++;
      end
      hold = out_valid && !out_ready;
      prev = out_win;
      if (in_valid && in_ready) acc++;
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    if (abort_at > 0) return;
    if (guard >= 20000) chk(0, "R5", "frame watchdog", WINW'(oc), WINW'(w*h));
    chk(acc == w*h, "R5", "pixels accepted per frame", WINW'(acc), WINW'(w*h));
    out_ready = 1'b1;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R5", "out_valid after last window", WINW'(out_valid), '0);
    chk(!in_ready, "R5", "in_ready after last line", WINW'(in_ready), '0);
    in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b1;
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    // R1: no traffic before the first sof
    chk(!in_ready, "R1", "in_ready before sof", WINW'(in_ready), '0);
    chk(!out_valid, "R1", "out_valid before sof", WINW'(out_valid), '0);
    in_valid = 1'b0;
    out_ready = 1'b0;

    run_frame(8, 12, 0, 0, 100, 60, 200, 0);   // R9 stall, RGGB
    run_frame(5, 5, 1, 1, 70, 70, 0, 0);       // BGGR, exact fill
    run_frame(1, 3, 0, 1, 80, 80, 0, 0);       // tiny frame, GRBG
    run_frame(64, 7, 1, 0, 90, 50, 0, 0);      // full width, GBRG
    run_frame(6, 9, 0, 1, 40, 90, 0, 0);
    run_frame(2, 1, 1, 1, 100, 100, 0, 0);     // single line
    run_frame(10, 8, 0, 0, 100, 30, 0, 15);    // abandoned by next sof
    // R10: frame after an abort must be complete and correct
    run_frame(7, 10, 1, 0, 60, 60, 0, 0);
    for (int k = 0; k < 3; k++)
      run_frame(3 + int'($urandom % 12), 1 + int'($urandom % 15),
                1'($urandom), 1'($urandom), 50 + int'($urandom % 50),
                50 + int'($urandom % 50), 0, 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule